// File: doc/BRIEF.md
# DMA Channel Control Register Unit

This block is the software-visible register file of a single DMA channel. A 32-bit, word-access slave port reaches four registers: a control/status word, the current memory address, a byte count and an upper-address base that the data path merges into its addresses. Reads return one cycle after the request with a valid strobe. Only address bits 3:2 select a register, so the block can sit at a base that is not page aligned.

The control word combines status and control. The top nibble always reads back as a fixed version code. Bit 0 is set and cleared by a level interrupt from the attached peripheral, and the gated interrupt output is raised only while that bit and the enable bit are both set. A control write with the reset bit set sends a one-cycle reset pulse to the peripheral instead of storing the bit. The drain bit follows its own write rules: a write of all zeros requests a drain, and writing the drain bit clears it.

Writing the address register sets an address-loaded flag in the control word. Each pulse on the transfer-completion strobe adds its byte length to the address register. The memory data path, arbitration and address translation belong to other blocks.

Top module: `dmar_top`

## Requirements
- R1: The register index is addr[3:2] (0 control, 1 address, 2 byte count, 3 base); all other address bits are ignored. A read accepted at a clock edge drives rdata and rvalid high at the next edge, and rvalid is high for exactly one cycle per read.
- R2: After reset the control word reads 0xA0000000, the other three registers read 0, and irq_out and per_rst are low.
- R3: On every control write, bits 31:28 are stored as 0xA whatever the data holds. Bits 27:1 come from the data, except for bits 6 and 7 (R4, R5, R6). Bit 8 is the to-memory direction select and bit 4 is the interrupt enable.
- R4: A control write with bit 7 set drives per_rst high for exactly the one cycle after the write edge. Bit 7 always reads back as 0, and with bit 7 set, bit 6 is stored as written.
- R5: A control write with bit 7 clear and bit 6 set stores bit 6 as 0.
- R6: A control write whose 32-bit data is exactly zero stores bit 6 as 1, so the word reads 0xA0000040 (plus bit 0).
- R7: An address-register write stores the data and sets control bit 26 (loaded). A control write takes bit 26 from its data.
- R8: Control bit 0 holds the value of per_irq at the previous clock edge. Writes do not change it.
- R9: irq_out is high exactly when control bit 0 and control bit 4 are both 1. It follows them in the same cycle.
- R10: A cycle with xfer_done high adds xfer_len to the address register, modulo 2^32. An address-register write in the same cycle takes precedence and the length is dropped.
- R11: The byte-count register (index 2) and the base register (index 3) store written data unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, accepted at the clock edge |
| rd_en | input | 1 | Read request, accepted at the clock edge |
| addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read data strobe, one cycle after rd_en |
| per_irq | input | 1 | Level interrupt from the peripheral |
| irq_out | output | 1 | Gated interrupt: pending AND enable |
| per_rst | output | 1 | One-cycle reset pulse to the peripheral |
| xfer_done | input | 1 | Transfer completion strobe |
| xfer_len | input | LEN_W | Byte length of the completed transfer |

## Verification
The control word is written with several patterns: plain enable and direction bits, a junk top nibble, all zeros, drain alone, reset with drain, and all ones. These separate the version forcing, the zero-to-drain rule, the self-clearing drain bit and the reset pulse. Address stimulus covers a single advance, a maximum-length advance, wrap past 2^32, and a write that coincides with a strobe, which shows the precedence rule. The interrupt input is toggled with the enable on and off, so a gating error is told apart from a pending-flag error. Reads at aliased addresses show that only bits 3:2 are decoded.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = 2;
  localparam int unsigned NUM_REGS = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IDX_CTL  = 2'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CNT  = 2'd2;
  localparam logic [IDX_W-1:0] IDX_BASE = 2'd3;

  localparam int unsigned B_PEND   = 0;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_DRAIN  = 6;
  localparam int unsigned B_PRST   = 7;
  localparam int unsigned B_LOADED = 26;

  localparam int unsigned VER_W   = 4;
  localparam logic [VER_W-1:0] VER_CODE = 4'hA;
endpackage

// File: rtl/dmar_ctl_reg.sv
module dmar_ctl_reg
  import dmar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load_set,
  input  logic              irq_lvl,
  output logic [DATA_W-1:0] ctl_q,
  output logic              rst_pulse
);
  logic [DATA_W-1:0] ctl_d;
  logic              pulse_d;
  logic [DATA_W-1:0] shaped;

  always_comb begin
    shaped  = wdata;
    pulse_d = 1'b0;
    if (wdata[B_PRST]) begin
      pulse_d = ctl_wr;
    end else if (wdata[B_DRAIN]) begin
      shaped[B_DRAIN] = 1'b0;
    end else if (wdata == '0) begin
      shaped[B_DRAIN] = 1'b1;
    end
    shaped[B_PRST] = 1'b0;
    shaped[DATA_W-1 -: VER_W] = VER_CODE;

    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d = shaped;
    end else if (load_set) begin
      ctl_d[B_LOADED] = 1'b1;
    end
    ctl_d[B_PEND] = irq_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= {VER_CODE, {(DATA_W-VER_W){1'b0}}};
      rst_pulse <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      rst_pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/dmar_addr_reg.sv
module dmar_addr_reg
  import dmar_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              adv,
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned PAD_W = DATA_W - LEN_W;

  logic [DATA_W-1:0] d;
  logic              en;

  always_comb begin
    en = wr | adv;
    if (wr) d = wdata;
    else    d = q + {{PAD_W{1'b0}}, len};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dmar_data_reg.sv
module dmar_data_reg
  import dmar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/dmar_top.sv
module dmar_top
  import dmar_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              per_irq,
  output logic              irq_out,
  output logic              per_rst,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len
);
  logic [IDX_W-1:0]  idx;
  logic [NUM_REGS-1:0] wr_sel;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] rdata_d;

  assign idx = addr[IDX_W+1:2];

  always_comb begin
    wr_sel = '0;
    wr_sel[idx] = wr_en;
  end

  dmar_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (wr_sel[IDX_CTL]),
    .wdata     (wdata),
    .load_set  (wr_sel[IDX_ADDR]),
    .irq_lvl   (per_irq),
    .ctl_q     (ctl_word),
    .rst_pulse (per_rst)
  );

  dmar_addr_reg #(.LEN_W(LEN_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_sel[IDX_ADDR]),
    .wdata (wdata),
    .adv   (xfer_done),
    .len   (xfer_len),
    .q     (regs[IDX_ADDR])
  );

  assign regs[IDX_CTL] = ctl_word;

  for (genvar g = IDX_CNT; g < NUM_REGS; g++) begin : g_plain
    dmar_data_reg u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_sel[g]),
      .wdata (wdata),
      .q     (regs[g])
    );
  end

  assign irq_out = ctl_word[B_PEND] & ctl_word[B_IEN];
  assign rdata_d = regs[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/dmar_checker.sv
module dmar_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  idx,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic        per_irq,
  input logic        irq_out,
  input logic        per_rst,
  input logic [31:0] ctl_word
);
  assert_rvalid_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid == $past(rd_en));

  assert_version_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(idx) == 2'd0) |-> rdata[31:28] == 4'hA);

  assert_pulse_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_rst == $past(wr_en && idx == 2'd0 && wdata[7]));

  assert_reset_bit_not_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_word[7]);

  assert_loaded_after_addr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && idx == 2'd1) |-> ctl_word[26]);

  assert_irq_needs_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(per_irq));
endmodule

bind dmar_top dmar_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .idx      (idx),
  .wdata    (wdata),
  .rdata    (rdata),
  .rvalid   (rvalid),
  .per_irq  (per_irq),
  .irq_out  (irq_out),
  .per_rst  (per_rst),
  .ctl_word (ctl_word)
);

// File: tb/sim_dmar_top.sv
`timescale 1ns/1ps
module sim_dmar_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, per_irq = 1'b0, xfer_done = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] xfer_len = '0;
  logic [31:0] rdata;
  logic        rvalid, irq_out, per_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmar_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .per_irq(per_irq),
    .irq_out(irq_out), .per_rst(per_rst), .xfer_done(xfer_done), .xfer_len(xfer_len)
  );

  // behavioural reference model
  logic [31:0] m_reg [4];
  logic [31:0] m_rd, v;
  logic        m_rv, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 32'hA000_0000; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_rv = 0; m_rd = 0; m_pulse = 0;
    end else begin
      m_rv = rd_en;
      if (rd_en) m_rd = m_reg[addr[3:2]];
      m_pulse = 0;
      if (xfer_done && !(wr_en && addr[3:2] == 1)) m_reg[1] = m_reg[1] + 32'(xfer_len);
      if (wr_en) begin
        case (addr[3:2])
          2'd0: begin
            v = wdata;
            if (v[7]) m_pulse = 1;
            else if (v[6]) v[6] = 0;
            else if (v == 0) v[6] = 1;
            v[7] = 0;
            v[31:28] = 4'hA;
            m_reg[0] = v;
          end
          2'd1: begin m_reg[1] = wdata; m_reg[0][26] = 1; end
          default: m_reg[addr[3:2]] = wdata;
        endcase
      end
      m_reg[0][0] = per_irq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rvalid !== m_rv) begin errors++; $display("FAIL R1 rvalid act=%0b exp=%0b", rvalid, m_rv); end
      if (m_rv) begin
        checks++;
        if (rdata !== m_rd) begin errors++; $display("FAIL R1 model rdata act=%h exp=%h", rdata, m_rd); end
      end
      checks++;
      if (irq_out !== (m_reg[0][0] & m_reg[0][4])) begin
        errors++; $display("FAIL R9 irq_out act=%0b exp=%0b", irq_out, m_reg[0][0] & m_reg[0][4]);
      end
      checks++;
      if (per_rst !== m_pulse) begin errors++; $display("FAIL R4 per_rst act=%0b exp=%0b", per_rst, m_pulse); end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    rd_en = 1; addr = a;
    tick();
    rd_en = 0;
    #2;
    chk(tag, rdata, exp);
  endtask

  task automatic xfer(logic [15:0] n);
    xfer_done = 1; xfer_len = n;
    tick();
    xfer_done = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    chk("R2 irq_out", {31'b0, irq_out}, 0);
    chk("R2 per_rst", {31'b0, per_rst}, 0);
    rd(8'h00, 32'hA000_0000, "R2 ctl");
    rd(8'h04, 0, "R2 addr");
    rd(8'h08, 0, "R2 count");
    rd(8'h0C, 0, "R2 base");

    wr(8'h00, 32'h0000_0110); rd(8'h00, 32'hA000_0110, "R3 enable+dir");
    wr(8'h00, 32'h5000_0000); rd(8'h00, 32'hA000_0000, "R3 nibble forced");
    wr(8'h00, 32'h0);         rd(8'h00, 32'hA000_0040, "R6 zero write");
    wr(8'h00, 32'h0000_0050); rd(8'h00, 32'hA000_0010, "R5 drain cleared");

    wdata = 32'h0000_00C0; addr = 8'h00; wr_en = 1;
    tick(); wr_en = 0; #2;
    chk("R4 pulse high", {31'b0, per_rst}, 1);
    tick(); #2;
    chk("R4 pulse one cycle", {31'b0, per_rst}, 0);
    rd(8'h00, 32'hA000_0040, "R4 bit7 not stored");
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'hAFFF_FF7E, "R3 all ones");

    wr(8'h00, 32'h0000_0040);
    wr(8'h04, 32'h0000_1000);
    rd(8'h00, 32'hA400_0000, "R7 loaded set");
    rd(8'h04, 32'h0000_1000, "R7 address stored");
    xfer(16'h0020);            rd(8'h04, 32'h0000_1020, "R10 advance");
    xfer(16'hFFFF);            rd(8'h04, 32'h0001_101F, "R10 max length");
    wr(8'h04, 32'hFFFF_FFF0); xfer(16'h0020); rd(8'h04, 32'h0000_0010, "R10 wrap");
    xfer_done = 1; xfer_len = 16'h8; wr(8'h04, 32'h0000_0500); xfer_done = 0;
    rd(8'h04, 32'h0000_0500, "R10 write wins");

    wr(8'h00, 32'h0000_0010); rd(8'h00, 32'hA000_0010, "R7 loaded from ctl data");
    per_irq = 1; tick(); #2;
    chk("R9 irq gated on", {31'b0, irq_out}, 1);
    rd(8'h00, 32'hA000_0011, "R8 pending set");
    wr(8'h00, 32'h0);
    #2 chk("R9 enable off", {31'b0, irq_out}, 0);
    rd(8'h00, 32'hA000_0041, "R8 write keeps pending");
    wr(8'h00, 32'h0000_0010);
    per_irq = 0; tick(); #2;
    chk("R8 pending follows input low", {31'b0, irq_out}, 0);
    rd(8'h00, 32'hA000_0010, "R8 pending cleared");

    wr(8'h08, 32'hDEAD_BEEF); wr(8'h0C, 32'h1234_5678);
    rd(8'h18, 32'hDEAD_BEEF, "R1 alias count");
    rd(8'h3C, 32'h1234_5678, "R11 base");
    rd(8'hF8, 32'hDEAD_BEEF, "R11 count");
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule